// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Register Slave

This block sits on a two-wire serial bus (I2C-style signalling) as a write-only slave. It oversamples the clock and data lines with the system clock, finds the bus framing conditions, and takes configuration bytes from a bus master into a bank of eight 8-bit control registers. The bank is exposed as one flat parallel output that drives the rest of the chip.

A transaction opens with a START, then carries the device address byte, then a subaddress byte, then any number of data bytes, and closes with a STOP. The subaddress gives a 4-bit register index and a stepping flag. With the flag clear, every data byte lands in the same register. With the flag set, each byte goes to the next index. Bytes aimed at indices 8 to 15 are acknowledged but dropped. The slave acknowledges by enabling an open-drain pull-low on the data line.

The controller has eight named states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK pulls the line low for the ninth clock after a matching address. ST_SKIP ignores the bus after a mismatch. ST_SUB shifts in the subaddress. ST_SUB_ACK acknowledges it. ST_DATA shifts in a data byte. ST_DATA_ACK acknowledges it.

The transitions are as follows. Any START goes to ST_ADDR, and any STOP goes to ST_IDLE. When the eighth bit of the address ends, ST_ADDR moves to ST_ADDR_ACK on a match and to ST_SKIP otherwise. When the eighth bit of a byte ends, ST_SUB moves to ST_SUB_ACK and ST_DATA moves to ST_DATA_ACK. Each acknowledge state leaves on the falling edge of the ninth clock: ST_ADDR_ACK to ST_SUB, ST_SUB_ACK to ST_DATA, and ST_DATA_ACK back to ST_DATA.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset every register reads 0 and the data-line pull-low enable is off.
- R2: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. Bits are sampled while the clock line is high.
- R3: A first byte equal to {DEV_ADDR, 1'b0} (address in bits 7:1, bit 0 = 0 for write) is acknowledged. Any other first byte, including one with bit 0 = 1, gets no acknowledge. The rest of the transaction up to the next START is then ignored: no register changes and no acknowledge is given.
- R4: After an accepted address, the slave pulls the data line low during the ninth clock of the subaddress byte and of every data byte.
- R5: Subaddress bits 3:0 are the register index and bit 4 is the stepping flag. Bits 7:5 have no effect.
- R6: With the stepping flag at 0, every data byte of the transaction is written to the one selected register, so the last byte wins.
- R7: With the stepping flag at 1, the first byte goes to the selected index and each later byte to the previous index plus one. The 4-bit index wraps from 15 to 0.
- R8: A data byte aimed at an index from 8 to 15 is acknowledged but changes no register.
- R9: A repeated START anywhere restarts address matching, including after a rejected address.
- R10: A STOP or START arriving before the eighth bit of a byte is complete discards the partial byte, and no register is written.
- R11: Bytes arrive most significant bit first.
- R12: Register k appears on regs_o bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| regs_o | output | 64 | Register bank, register k in bits [8k+7:8k] |

## Verification
The bound checker watches four things on every cycle. The pull-low enable changes only right after a detected clock fall or a framing condition. The enable is off after a STOP. The register outputs change only just after a clock fall. No more than one register changes at a time.

Other behaviours can only be shown by the bench's scenarios, because each depends on a whole byte sequence:
- address matching and rejection
- the meaning of the subaddress fields
- the last-byte-wins and stepping write modes
- index wrap and the discarding of the upper indices
- partial-byte aborts and repeated STARTs
- bit order

The bench sweeps every start index in both modes and every single-bit corruption of the address byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] last;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last <= '1;
        end else begin
            last <= synced;
        end
    end

    // bit 1 is the clock line, bit 0 the data line
    assign sda_o      = synced[0];
    assign scl_rise_o = synced[1] & ~last[1];
    assign scl_fall_o = ~synced[1] & last[1];
    assign start_o    = synced[1] & last[1] & last[0] & ~synced[0];
    assign stop_o     = synced[1] & last[1] & ~last[0] & synced[0];
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h44,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_bit,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              pull_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int unsigned CNT_W    = $clog2(BYTE_W) + 1;
    localparam int unsigned AUTO_BIT = IDX_W;

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              step;
    logic              byte_done;
    logic              addr_hit;
    logic              shifting;
    logic              ack_state;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[7:1] == DEV_ADDR) && !shreg[0];
    assign shifting  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign ack_state = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_nx = ST_SUB;
                ST_SUB:      if (byte_done) state_nx = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_nx = ST_DATA;
                ST_SKIP:     state_nx = ST_SKIP;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // byte assembly and index tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            idx     <= '0;
            step    <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            if (shifting && scl_rise && (bit_cnt < CNT_W'(BYTE_W))) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (ack_state && scl_fall) begin
                bit_cnt <= '0;
            end
            if ((state == ST_SUB) && byte_done) begin
                idx  <= shreg[IDX_W-1:0];
                step <= shreg[AUTO_BIT];
            end
            if ((state == ST_DATA) && byte_done && step) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pull_o    = ack_state;
        wr_en_o   = (state == ST_DATA) && byte_done && !start_det && !stop_det
                    && (int'(idx) < int'(NUM_REGS));
        wr_idx_o  = idx;
        wr_data_o = shreg;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [BYTE_W-1:0] value;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                value <= wr_data;
            end
        end
        assign regs_o[k*BYTE_W +: BYTE_W] = value;
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h44,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned IDX_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic              sda_s;
    logic              scl_rise_w;
    logic              scl_fall_w;
    logic              start_w;
    logic              stop_w;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_cfg_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_bit   (sda_s),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .pull_o    (sda_pull_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    i2c_reg_bank #(
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs_o)
    );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
    parameter int unsigned NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_pull_o,
    input logic [NUM_REGS*8-1:0] regs_o
);
    logic [NUM_REGS*8-1:0] regs_q;
    logic [NUM_REGS-1:0]   changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_o;
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chg
        assign changed[k] = regs_q[k*8 +: 8] != regs_o[k*8 +: 8];
    end

    // R4
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull_o);

    // R10
    write_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(scl_fall));

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(changed) <= 1);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_fall   (scl_fall_w),
    .start_det  (start_w),
    .stop_det   (stop_w),
    .sda_pull_o (sda_pull_o),
    .regs_o     (regs_o)
);

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
    localparam logic [6:0] ADDR = 7'h44;
    localparam int NR = 8;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [NR*8-1:0] regs;
    logic sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [NR];

    assign sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2c_cfg_slave #(.DEV_ADDR(ADDR), .NUM_REGS(NR), .IDX_W(4)) i_i2c_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .regs_o     (regs)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = ~sda_bus;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic check_bank(input string tag);
        for (int k = 0; k < NR; k++) chk(regs[k*8 +: 8], model[k], tag);
    endtask

    task automatic write_txn(input logic [3:0] idx, input logic stepping,
                             input logic [2:0] upper, input int nbytes, input int seed,
                             input string tag);
        logic a;
        logic [3:0] p;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk(a, 1, {tag, " R3 addr ack"});
        send_byte({upper, stepping, idx}, a);
        chk(a, 1, {tag, " R4 sub ack"});
        p = idx;
        for (int j = 0; j < nbytes; j++) begin
            d = 8'((seed * 37 + j * 91 + 5) & 255);
            send_byte(d, a);
            chk(a, 1, {tag, " R4 data ack"});
            if (int'(p) < NR) model[p] = d;
            if (stepping) p = p + 4'd1;
        end
        bus_stop();
        chk(sda_pull, 0, {tag, " R2 released after stop"});
        check_bank(tag);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic a;
        for (int k = 0; k < NR; k++) model[k] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        chk(regs, 0, "R1 regs reset");
        chk(sda_pull, 0, "R1 pull off after reset");
        check_bank("R12 layout reset");

        // R6 single-register mode over every index, two bytes each, last wins
        for (int i = 0; i < 16; i++)
            write_txn(4'(i), 1'b0, 3'((i * 3) & 7), 2, i, "R6/R5/R8 fixed");

        // R7 stepping mode from every start index, wraps and drops upper
        for (int i = 0; i < 16; i++)
            write_txn(4'(i), 1'b1, 3'((i * 5) & 7), 4, i + 40, "R7/R8/R12 step");

        // R11 bit order: 0x80 and 0x01 land as written
        write_txn(4'd3, 1'b0, 3'd0, 1, 0, "R11 prep");
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h15, a);
        send_byte(8'h80, a);
        send_byte(8'h01, a);
        bus_stop();
        model[5] = 8'h80; model[6] = 8'h01;
        chk(regs[5*8 +: 8], 8'h80, "R11 msb first 80");
        chk(regs[6*8 +: 8], 8'h01, "R11 msb first 01");

        // R3 address bytes with one bit flipped, all refused and ignored
        for (int b = 0; b < 8; b++) begin
            logic [7:0] bad;
            bad = {ADDR, 1'b0} ^ (8'h01 << b);
            bus_start();
            send_byte(bad, a);
            chk(a, 0, "R3 bad addr no ack");
            send_byte(8'h02, a);
            chk(a, 0, "R3 ignored sub no ack");
            send_byte(8'hA5, a);
            chk(a, 0, "R3 ignored data no ack");
            bus_stop();
            check_bank("R3 bank untouched");
        end

        // R9 repeated start after a rejected address
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk(a, 0, "R9 read dir refused");
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk(a, 1, "R9 restart accepted");
        send_byte(8'h01, a);
        send_byte(8'h3C, a);
        bus_stop();
        model[1] = 8'h3C;
        check_bank("R9 write after restart");

        // R10 stop mid-byte discards partial
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h02, a);
        send_bits(8'hFF, 4);
        bus_stop();
        check_bank("R10 stop mid-byte");

        // R10 start mid-byte discards partial, then restart works (R9)
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h04, a);
        send_bits(8'h00, 7);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        chk(a, 1, "R9 restart mid-byte accepted");
        send_byte(8'h07, a);
        send_byte(8'hC3, a);
        bus_stop();
        model[7] = 8'hC3;
        check_bank("R10 start mid-byte");

        finish_run();
    end
endmodule